// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command pins from reset until the memory can accept normal traffic. After reset is released it drives a no-operation command for a settle interval, with clock-enable and every data-mask line held high. It then closes all banks with one precharge-all command. Once the row-precharge time has passed, it issues a programmable number of auto-refresh commands spaced by the row-cycle time. It ends by loading the mode register from a static configuration byte.

The configuration byte is placed onto the address pins during the mode-register load, in the bit positions the memory decodes. After the mode-register recovery time, `init_done` goes high and stays high. All waits are parameters counted in clock cycles. The defaults suit a 100 MHz clock: a 500 µs settle, 2-cycle precharge time, 7-cycle refresh spacing and 2-cycle mode-register recovery. A refresh count below eight is raised to eight. All pin outputs are registered.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, and for SETTLE_CYC cycles after it is released, the block holds `sd_cke`=1, every `sd_dqm` bit at 1, BA=0, A=0 and `init_done`=0. The command is NOP, encoded as cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R2: In cycle SETTLE_CYC+1 after release the command is precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0), with A10=1 and every other A bit and BA at 0.
- R3: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, A=0, BA=0) appears exactly TRP_CYC cycles after precharge-all, with NOP in the cycles between.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued, raised to 8 if smaller. Each follows the previous one by exactly TRC_CYC cycles, with NOP between them.
- R5: Mode-register-set (cs_n=0, ras_n=0, cas_n=0, we_n=0) appears exactly TRC_CYC cycles after the last auto-refresh and is issued once.
- R6: During mode-register-set, BA=0 and A11, A10, A8 and A7 are 0. A9 carries `mode_cfg[7]` (write mode), A6..A4 carry `mode_cfg[6:4]` (CAS latency, 010=2, 011=3), A3 carries `mode_cfg[3]` (burst type) and A2..A0 carry `mode_cfg[2:0]` (burst length). Reserved codes are passed through unchanged.
- R7: `init_done` rises exactly TRSC_CYC cycles after the mode-register-set cycle and stays high until reset. From mode-register-set onward the command stays NOP, with `sd_cke` and `sd_dqm` high.
- R8: Driving `rst_n` low at any point of the sequence returns the outputs to the R1 state, and the next release restarts the whole sequence from the settle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cfg | input | 8 | Static mode word: [7] write mode, [6:4] CAS latency, [3] burst type, [2:0] burst length |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address pins |
| sd_dqm | output | DQM_W | Data mask lines |
| init_done | output | 1 | High once the memory is ready |

## Verification
The assertions assume that `mode_cfg` does not change while a sequence is running. They compare the address bits at the mode-register-set cycle directly against the live configuration port. They also assume that every gap parameter is at least one cycle. The stimulus sets a new configuration only while reset is held, and it uses small gap values that are all at least one, including an unequal refresh spacing and precharge time. One run drops reset partway through the refresh phase, so the restart path is exercised without ever changing the configuration mid-run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int MODE_W = 12;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    PEND_PRE,
    PEND_REF,
    PEND_MRS,
    PEND_DONE,
    PEND_IDLE
  } pend_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  // Strobe levels for each command the sequencer can issue.
  function automatic strobe_t encode_cmd(cmd_e c);
    strobe_t s;
    case (c)
      CMD_PREA: s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS:  s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return s;
  endfunction

  // Places the configuration byte where the memory decodes it on the address pins.
  function automatic logic [MODE_W-1:0] pack_mode(logic [7:0] cfg);
    logic [MODE_W-1:0] r;
    r      = '0;
    r[9]   = cfg[7];
    r[6:0] = cfg[6:0];
    return r;
  endfunction

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W    = 16,
  parameter int INIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= W'(INIT);
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/sdram_init_refctr.sv
module sdram_init_refctr #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] remaining;

  assign last = (remaining == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remaining <= '0;
    else if (load)                   remaining <= CW'(N);
    else if (dec && remaining != '0) remaining <= remaining - 1'b1;
  end

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_sel,
  input  logic [ADDR_W-1:0] mode_addr,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  strobe_t strobe_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    strobe_d = encode_cmd(cmd_sel);
    case (cmd_sel)
      CMD_PREA: addr_d = ALL_BANKS;
      CMD_MRS:  addr_d = mode_addr;
      default:  addr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= encode_cmd(CMD_NOP);
      sd_addr <= '0;
      sd_ba   <= '0;
      sd_cke  <= 1'b1;
      sd_dqm  <= '1;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= strobe_d;
      sd_addr <= addr_d;
      sd_ba   <= '0;
      sd_cke  <= 1'b1;
      sd_dqm  <= '1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int SETTLE_CYC    = 50000,
  parameter int TRP_CYC       = 2,
  parameter int TRC_CYC       = 7,
  parameter int TRSC_CYC      = 2,
  parameter int REFRESH_COUNT = 8,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mode_cfg,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int REF_N = (REFRESH_COUNT < 8) ? 8 : REFRESH_COUNT;
  localparam int TMR_W = $clog2(max_of4(SETTLE_CYC, TRP_CYC, TRC_CYC, TRSC_CYC) + 1);

  pend_e pend;
  logic  done_q;
  logic  tmr_zero;
  logic  ref_last;

  // Named internal events, observed by the bound checker.
  logic gap_expired;
  logic issue_pre;
  logic issue_ref;
  logic issue_mrs;
  logic finish_wait;
  logic any_load;

  logic [TMR_W-1:0]  load_val;
  cmd_e              cmd_sel;
  logic [ADDR_W-1:0] mode_addr;

  assign gap_expired = tmr_zero && (pend != PEND_IDLE);
  assign issue_pre   = gap_expired && (pend == PEND_PRE);
  assign issue_ref   = gap_expired && (pend == PEND_REF);
  assign issue_mrs   = gap_expired && (pend == PEND_MRS);
  assign finish_wait = gap_expired && (pend == PEND_DONE);
  assign any_load    = issue_pre || issue_ref || issue_mrs;
  assign mode_addr   = ADDR_W'(pack_mode(mode_cfg));

  always_comb begin
    case (pend)
      PEND_PRE: load_val = TMR_W'(TRP_CYC - 1);
      PEND_REF: load_val = TMR_W'(TRC_CYC - 1);
      PEND_MRS: load_val = TMR_W'(TRSC_CYC - 1);
      default:  load_val = '0;
    endcase
  end

  always_comb begin
    if (issue_pre)      cmd_sel = CMD_PREA;
    else if (issue_ref) cmd_sel = CMD_REF;
    else if (issue_mrs) cmd_sel = CMD_MRS;
    else                cmd_sel = CMD_NOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= PEND_PRE;
      done_q <= 1'b0;
    end else begin
      if (issue_pre)        pend <= PEND_REF;
      else if (issue_ref)   pend <= ref_last ? PEND_MRS : PEND_REF;
      else if (issue_mrs)   pend <= PEND_DONE;
      else if (finish_wait) pend <= PEND_IDLE;
      if (finish_wait) done_q <= 1'b1;
    end
  end

  assign init_done = done_q;

  sdram_init_timer #(
    .W    (TMR_W),
    .INIT (SETTLE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (any_load),
    .load_val (load_val),
    .zero     (tmr_zero)
  );

  sdram_init_refctr #(
    .N (REF_N)
  ) u_refctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (issue_pre),
    .dec   (issue_ref),
    .last  (ref_last)
  );

  sdram_init_pins #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .DQM_W  (DQM_W)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_sel   (cmd_sel),
    .mode_addr (mode_addr),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm)
  );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int SETTLE_CYC    = 50000,
  parameter int TRP_CYC       = 2,
  parameter int TRC_CYC       = 7,
  parameter int TRSC_CYC      = 2,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        mode_cfg,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done,
  input logic              issue_mrs
);

  localparam int SAT = 1 << 30;

  logic is_nop, is_pre, is_ref, is_mrs, is_cmd;
  assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
  assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
  assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
  assign is_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
  assign is_cmd = !is_nop;

  int   age;
  int   since;
  int   refs_seen;
  logic last_pre, last_ref, last_mrs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age       <= 0;
      since     <= 0;
      refs_seen <= 0;
      last_pre  <= 1'b0;
      last_ref  <= 1'b0;
      last_mrs  <= 1'b0;
    end else begin
      if (age < SAT) age <= age + 1;
      if (is_cmd) begin
        since    <= 1;
        last_pre <= is_pre;
        last_ref <= is_ref;
        last_mrs <= is_mrs;
      end else if (since < SAT) begin
        since <= since + 1;
      end
      if (is_ref) refs_seen <= refs_seen + 1;
    end
  end

  // R1
  cke_dqm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke && (&sd_dqm));

  // R1
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && !last_pre && !last_ref && !last_mrs) |-> (age == SETTLE_CYC + 1));

  // R2
  prea_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sd_addr[10] && $countones(sd_addr) == 1 && sd_ba == '0));

  // R3
  first_ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_pre) |-> (since == TRP_CYC));

  // R4
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_ref) |-> (since == TRC_CYC));

  // R4
  enough_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (refs_seen >= 8));

  // R5
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (last_ref && since == TRC_CYC));

  // R5
  mrs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_mrs |=> is_mrs);

  // R6
  mrs_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_ba == '0 && !sd_addr[11] && !sd_addr[10] && !sd_addr[8] && !sd_addr[7]
                && sd_addr[9] == mode_cfg[7] && sd_addr[6:0] == mode_cfg[6:0]));

  // R7
  done_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last_mrs && since == TRSC_CYC));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .TRP_CYC    (TRP_CYC),
  .TRC_CYC    (TRC_CYC),
  .TRSC_CYC   (TRSC_CYC),
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .DQM_W      (DQM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_cfg  (mode_cfg),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .sd_dqm    (sd_dqm),
  .init_done (init_done),
  .issue_mrs (issue_mrs)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int S    = 20;
  localparam int TRP  = 3;
  localparam int TRC  = 6;
  localparam int TRSC = 2;
  localparam int NREF = 9;
  localparam int AW   = 12;
  localparam int BW   = 2;
  localparam int DW   = 9;

  // Event kinds in the reference schedule.
  localparam int K_NOP = 0;
  localparam int K_PRE = 1;
  localparam int K_REF = 2;
  localparam int K_MRS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    mode_cfg = 8'h00;
  logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [BW-1:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic [DW-1:0] sd_dqm;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int sched_cyc[$];
  int sched_kind[$];
  int done_cyc;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  sdram_init_seq #(
    .SETTLE_CYC    (S),
    .TRP_CYC       (TRP),
    .TRC_CYC       (TRC),
    .TRSC_CYC      (TRSC),
    .REFRESH_COUNT (NREF),
    .ADDR_W        (AW),
    .BA_W          (BW),
    .DQM_W         (DW)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cfg  (mode_cfg),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .init_done (init_done)
  );

  // Build the expected command timeline from the requirement timing rules.
  task automatic build_schedule();
    int t;
    sched_cyc.delete();
    sched_kind.delete();
    t = S + 1;
    sched_cyc.push_back(t); sched_kind.push_back(K_PRE);
    t = t + TRP;
    for (int i = 0; i < NREF; i++) begin
      sched_cyc.push_back(t); sched_kind.push_back(K_REF);
      t = t + TRC;
    end
    sched_cyc.push_back(t); sched_kind.push_back(K_MRS);
    done_cyc = t + TRSC;
  endtask

  function automatic int kind_at(int n);
    foreach (sched_cyc[i]) if (sched_cyc[i] == n) return sched_kind[i];
    return K_NOP;
  endfunction

  function automatic logic [28:0] expect_vec(int n, int kind, logic [7:0] cfg);
    logic [3:0]    st;
    logic [AW-1:0] a;
    a = '0;
    case (kind)
      K_PRE:   begin st = 4'b0010; a[10] = 1'b1; end
      K_REF:   st = 4'b0001;
      K_MRS:   begin st = 4'b0000; a[9] = cfg[7]; a[6:4] = cfg[6:4]; a[3] = cfg[3]; a[2:0] = cfg[2:0]; end
      default: st = 4'b0111;
    endcase
    return {1'b1, {DW{1'b1}}, st, {BW{1'b0}}, a, (n > 0 && n >= done_cyc)};
  endfunction

  task automatic compare(string tag_override, logic [7:0] cfg);
    int          n;
    int          kind;
    string       tag;
    logic [28:0] exp_v, act_v;
    n     = cyc;
    kind  = kind_at(n);
    exp_v = expect_vec(n, kind, cfg);
    act_v = {sd_cke, sd_dqm, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, init_done};
    if (tag_override != "")   tag = tag_override;
    else if (kind == K_PRE)   tag = "R2";
    else if (kind == K_REF)   tag = (n == S + 1 + TRP) ? "R3" : "R4";
    else if (kind == K_MRS)   tag = "R5 R6";
    else if (n >= done_cyc)   tag = "R7";
    else if (n <= S)          tag = "R1";
    else                      tag = "R4";
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, n, act_v, exp_v);
    end
  endtask

  // One initialization run; abort_at > 0 drops reset at that cycle (R8).
  task automatic run_init(logic [7:0] cfg, int abort_at);
    @(negedge clk);
    rst_n    = 1'b0;
    mode_cfg = cfg;
    build_schedule();
    repeat (2) begin
      @(negedge clk);
      compare("R1", cfg);
    end
    rst_n = 1'b1;
    forever begin
      @(negedge clk);
      compare("", cfg);
      if (abort_at > 0 && cyc == abort_at) begin
        rst_n = 1'b0;
        repeat (3) begin
          @(negedge clk);
          compare("R8", cfg);
        end
        break;
      end
      if (cyc >= done_cyc + 8) break;
    end
  endtask

  initial begin
    // CAS latency 2, sequential, burst of 8, burst write.
    run_init(8'b0_010_0_011, 0);
    // CAS latency 3, interleaved, burst of 4, single write.
    run_init(8'b1_011_1_010, 0);
    // Reset dropped in the middle of the refresh phase.
    run_init(8'b0_011_0_001, S + 1 + TRP + 2 * TRC + 1);
    // Reserved codes pass straight through.
    run_init(8'b1_111_0_111, 0);
    // Sequence restarted after the aborted run, all-zero word.
    run_init(8'b0_000_0_000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule